// File: doc/BRIEF.md
# Receive station address filter

This block screens incoming Ethernet frames by their 48-bit destination address. The destination address arrives as six byte-wide beats. The first beat on the wire is marked with a start-of-frame flag. In the cycle after the sixth byte, the block presents a registered verdict. The verdict has three parts: a valid flag, an accept bit, and a two-bit destination class (unicast, multicast or broadcast). It holds the verdict until the next start-of-frame beat arrives.

Software programs the filter through two registers: a control register and a data register. A control write with bit 31 clear turns the filter off and selects one of three 16-bit station-address words. Data writes then fill the selected word, and the data port reads it back. A control write with bit 31 set turns the filter on and loads the four accept flags. The accept flags cover all broadcast, all multicast, all unicast, and an exact station match. All of them pass through one global enable.

Top module: `rx_dest_filter`

## Requirements
- R1: After a synchronous reset, dec_valid, dec_accept and dec_class are 0, all station words and mode flags are 0, the selection is word 0, and cfg_rdata is 0.
- R2: Station word k (k = 0, 1, 2) is selected by a control write (cfg_is_data = 0) with bit 31 clear and k in bits 2:1. Bits 7:0 of word k hold destination byte 2k, the byte that arrives earlier on the wire, and bits 15:8 hold byte 2k+1. A data write stores cfg_wdata[15:0] into the selected word. cfg_rdata returns that word zero-extended. With selection value 3, data writes change nothing and cfg_rdata reads 0.
- R3: A control write with bit 31 set loads the mode and leaves the selection unchanged. The bits load as follows: 31 is enable, 30 accepts all broadcast, 29 accepts all multicast, 28 accepts all unicast, 27 accepts an exact match. A control write with bit 31 clear clears the enable and leaves bits 30:27 of the mode unchanged.
- R4: While enable is clear at the sixth byte, the frame is rejected whatever its address.
- R5: A destination of all ones gets class 2 (broadcast), and with enable set it is accepted when the broadcast flag is set. Class 3 never appears.
- R6: A destination that is not broadcast and whose first byte has bit 0 set gets class 1 (multicast). With enable set, it is accepted when the multicast flag is set.
- R7: Any other destination gets class 0 (unicast). With enable set, it is accepted when the unicast flag is set.
- R8: With enable set, a destination equal to the 48-bit station address is accepted when the exact-match flag is set, whatever its class.
- R9: The verdict's timing and framing work as follows:
  - dec_valid rises one cycle after the clock edge that samples the sixth byte.
  - Idle cycles inside the address do not disturb the verdict.
  - Beats after the sixth byte leave the verdict unchanged.
  - Beats arriving before any start-of-frame are ignored.
  - A start-of-frame beat clears dec_valid in the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_is_data | input | 1 | 1 selects the data register, 0 the control register |
| cfg_wdata | input | 32 | Register write value |
| cfg_rdata | output | 32 | Selected station word, zero-extended |
| rx_valid | input | 1 | Destination byte beat valid |
| rx_sof | input | 1 | Beat is the first destination byte |
| rx_byte | input | 8 | Destination byte |
| dec_valid | output | 1 | Verdict present |
| dec_accept | output | 1 | Frame accepted |
| dec_class | output | 2 | 0 unicast, 1 multicast, 2 broadcast |

## Verification
The bench sweeps all 32 mode patterns against four destinations: broadcast, a foreign multicast, the station address, and a foreign unicast. It computes the expected class and verdict from the flag rules. It also uses a multicast station address, so an exact match has to win for a destination whose class flag is off; a design that gated exact matching by class would reject that frame.

Further cases cover the shared enable bit, the byte order within each station word, and the unused word selection. A design that swapped the bytes would miss every exact match. A design that let a selection write keep the filter enabled would accept frames the requirements reject. Framing cases include gaps inside the address, beats after the sixth byte, and beats before any start-of-frame; a counter that did not idle after the sixth byte would overwrite a held verdict.

// File: rtl/dfilt_pkg.sv
package dfilt_pkg;

    localparam int ADDR_BYTES = 6;
    localparam int WORD_W     = 16;
    localparam int REG_W      = 32;

    typedef enum logic [1:0] {
        DST_UNI   = 2'd0,
        DST_MULTI = 2'd1,
        DST_BCAST = 2'd2
    } dst_class_e;

    typedef struct packed {
        logic enable;
        logic all_bcast;
        logic all_mcast;
        logic all_ucast;
        logic exact;
    } fmode_t;

    // New mode after a control-register write: bit 31 set loads all five
    // bits, bit 31 clear only drops the enable.
    function automatic fmode_t mode_load(fmode_t old, logic [31:0] w);
        fmode_t m;
        if (w[31]) begin
            m = fmode_t'(w[31:27]);
        end else begin
            m = old;
            m.enable = 1'b0;
        end
        return m;
    endfunction

    function automatic logic verdict(fmode_t m, dst_class_e c, logic hit);
        logic pass;
        pass = (c == DST_BCAST && m.all_bcast)
             | (c == DST_MULTI && m.all_mcast)
             | (c == DST_UNI   && m.all_ucast)
             | (hit && m.exact);
        return m.enable && pass;
    endfunction

endpackage

// File: rtl/dfilt_cfg.sv
module dfilt_cfg
    import dfilt_pkg::*;
#(
    parameter int NWORDS = 3,
    parameter int WW     = 16,
    parameter int RW     = 32
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 cfg_we,
    input  logic                 cfg_is_data,
    input  logic [RW-1:0]        cfg_wdata,
    output logic [RW-1:0]        cfg_rdata,
    output logic [NWORDS*WW-1:0] station,
    output fmode_t               mode
);

    localparam int SEL_W = $clog2(NWORDS + 1);

    logic [SEL_W-1:0] sel_q;
    fmode_t           mode_q;
    logic             ctl_wr;
    logic             dat_wr;

    assign ctl_wr = cfg_we && !cfg_is_data;
    assign dat_wr = cfg_we &&  cfg_is_data;

    always_ff @(posedge clk) begin
        if (rst) begin
            sel_q  <= '0;
            mode_q <= '0;
        end else if (ctl_wr) begin
            mode_q <= mode_load(mode_q, cfg_wdata[31:0]);
            if (!cfg_wdata[31]) begin
                sel_q <= cfg_wdata[SEL_W:1];
            end
        end
    end

    for (genvar k = 0; k < NWORDS; k++) begin : g_word
        logic [WW-1:0] word_q;
        always_ff @(posedge clk) begin
            if (rst) begin
                word_q <= '0;
            end else if (dat_wr && sel_q == SEL_W'(k)) begin
                word_q <= cfg_wdata[WW-1:0];
            end
        end
        assign station[k*WW +: WW] = word_q;
    end

    always_comb begin
        cfg_rdata = '0;
        for (int k = 0; k < NWORDS; k++) begin
            if (sel_q == SEL_W'(k)) begin
                cfg_rdata[WW-1:0] = station[k*WW +: WW];
            end
        end
    end

    assign mode = mode_q;

    logic unused_mid;
    assign unused_mid = ^cfg_wdata[RW-6:WW] ^ cfg_wdata[0];

    AST_SELECT_DISABLES: assert property (@(posedge clk) disable iff (rst)
        (ctl_wr && !cfg_wdata[31]) |=> !mode.enable);  // R3
    AST_FLAGS_KEPT: assert property (@(posedge clk) disable iff (rst)
        (ctl_wr && !cfg_wdata[31]) |=> $stable(mode[3:0]));  // R3
    AST_MODE_QUIET: assert property (@(posedge clk) disable iff (rst)
        !ctl_wr |=> $stable(mode));  // R3

endmodule

// File: rtl/dfilt_capture.sv
module dfilt_capture #(
    parameter int NB = 6
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            rx_valid,
    input  logic            rx_sof,
    input  logic [7:0]      rx_byte,
    output logic [NB*8-1:0] addr_full,
    output logic            fire
);

    localparam int CNT_W = $clog2(NB + 1);

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] pos;
    logic             take;

    always_comb begin
        take = rx_valid && (rx_sof || cnt_q != CNT_W'(NB));
        pos  = rx_sof ? '0 : cnt_q;
        fire = take && (pos == CNT_W'(NB - 1));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= CNT_W'(NB);
        end else if (take) begin
            cnt_q <= pos + CNT_W'(1);
        end
    end

    for (genvar i = 0; i < NB; i++) begin : g_byte
        if (i == NB - 1) begin : g_last
            assign addr_full[i*8 +: 8] = rx_byte;
        end else begin : g_held
            logic [7:0] byte_q;
            always_ff @(posedge clk) begin
                if (rst) begin
                    byte_q <= '0;
                end else if (take && pos == CNT_W'(i)) begin
                    byte_q <= rx_byte;
                end
            end
            assign addr_full[i*8 +: 8] = byte_q;
        end
    end

    AST_CNT_RANGE: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= CNT_W'(NB));  // R9
    AST_IDLE_AFTER_FIRE: assert property (@(posedge clk) disable iff (rst)
        fire |=> (cnt_q == CNT_W'(NB)));  // R9

endmodule

// File: rtl/dfilt_decide.sv
module dfilt_decide
    import dfilt_pkg::*;
#(
    parameter int NB = 6
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            fire,
    input  logic            sof_beat,
    input  logic [NB*8-1:0] addr_full,
    input  logic [NB*8-1:0] station,
    input  fmode_t          mode,
    output logic            dec_valid,
    output logic            dec_accept,
    output logic [1:0]      dec_class
);

    dst_class_e cls;
    logic       hit;
    dst_class_e class_q;
    logic       valid_q;
    logic       accept_q;

    always_comb begin
        hit = (addr_full == station);
        if (&addr_full) begin
            cls = DST_BCAST;
        end else if (addr_full[0]) begin
            cls = DST_MULTI;
        end else begin
            cls = DST_UNI;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q  <= 1'b0;
            accept_q <= 1'b0;
            class_q  <= DST_UNI;
        end else if (fire) begin
            valid_q  <= 1'b1;
            accept_q <= verdict(mode, cls, hit);
            class_q  <= cls;
        end else if (sof_beat) begin
            valid_q  <= 1'b0;
            accept_q <= 1'b0;
            class_q  <= DST_UNI;
        end
    end

    assign dec_valid  = valid_q;
    assign dec_accept = accept_q;
    assign dec_class  = class_q;

    AST_OFF_REJECTS: assert property (@(posedge clk) disable iff (rst)
        (fire && !mode.enable) |=> !dec_accept);  // R4
    AST_CLASS_LEGAL: assert property (@(posedge clk) disable iff (rst)
        dec_valid |-> (dec_class != 2'b11));  // R5
    AST_VERDICT_HELD: assert property (@(posedge clk) disable iff (rst)
        (dec_valid && !sof_beat) |=> (dec_valid && $stable(dec_accept) && $stable(dec_class)));  // R9

endmodule

// File: rtl/rx_dest_filter.sv
module rx_dest_filter
    import dfilt_pkg::*;
#(
    parameter int NBYTES = ADDR_BYTES,
    parameter int WW     = WORD_W,
    parameter int RW     = REG_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          cfg_we,
    input  logic          cfg_is_data,
    input  logic [RW-1:0] cfg_wdata,
    output logic [RW-1:0] cfg_rdata,
    input  logic          rx_valid,
    input  logic          rx_sof,
    input  logic [7:0]    rx_byte,
    output logic          dec_valid,
    output logic          dec_accept,
    output logic [1:0]    dec_class
);

    localparam int NWORDS = NBYTES * 8 / WW;

    logic [NBYTES*8-1:0] station;
    logic [NBYTES*8-1:0] addr_full;
    fmode_t              mode;
    logic                fire;
    logic                sof_beat;

    assign sof_beat = rx_valid && rx_sof;

    dfilt_cfg #(.NWORDS(NWORDS), .WW(WW), .RW(RW)) i_cfg (
        .clk        (clk),
        .rst        (rst),
        .cfg_we     (cfg_we),
        .cfg_is_data(cfg_is_data),
        .cfg_wdata  (cfg_wdata),
        .cfg_rdata  (cfg_rdata),
        .station    (station),
        .mode       (mode)
    );

    dfilt_capture #(.NB(NBYTES)) i_capture (
        .clk      (clk),
        .rst      (rst),
        .rx_valid (rx_valid),
        .rx_sof   (rx_sof),
        .rx_byte  (rx_byte),
        .addr_full(addr_full),
        .fire     (fire)
    );

    dfilt_decide #(.NB(NBYTES)) i_decide (
        .clk       (clk),
        .rst       (rst),
        .fire      (fire),
        .sof_beat  (sof_beat),
        .addr_full (addr_full),
        .station   (station),
        .mode      (mode),
        .dec_valid (dec_valid),
        .dec_accept(dec_accept),
        .dec_class (dec_class)
    );

    AST_SOF_CLEARS: assert property (@(posedge clk) disable iff (rst)
        sof_beat |=> !dec_valid);  // R9
    AST_RISE_ON_BEAT: assert property (@(posedge clk) disable iff (rst)
        $rose(dec_valid) |-> $past(rx_valid));  // R9

endmodule

// File: tb/test_rx_dest_filter.sv
module test_rx_dest_filter;

    localparam int CLK_PERIOD = 10;
    localparam logic [47:0] STATION = 48'h554433221102;
    localparam logic [47:0] MC_STATION = 48'hA0B0C0D0E001;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_we = 1'b0;
    logic        cfg_is_data = 1'b0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic        rx_valid = 1'b0;
    logic        rx_sof = 1'b0;
    logic [7:0]  rx_byte = '0;
    logic        dec_valid;
    logic        dec_accept;
    logic [1:0]  dec_class;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    rx_dest_filter i_rx_dest_filter (
        .clk(clk), .rst(rst),
        .cfg_we(cfg_we), .cfg_is_data(cfg_is_data),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .rx_valid(rx_valid), .rx_sof(rx_sof), .rx_byte(rx_byte),
        .dec_valid(dec_valid), .dec_accept(dec_accept), .dec_class(dec_class)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic reg_wr(input bit is_data, input logic [31:0] v);
        cfg_we = 1'b1; cfg_is_data = is_data; cfg_wdata = v;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic load_station(input logic [47:0] s);
        for (int k = 0; k < 3; k++) begin
            reg_wr(1'b0, 32'(k * 2));
            reg_wr(1'b1, {16'h0, s[k*16 +: 16]});
        end
    endtask

    task automatic set_mode(input logic [4:0] m);
        reg_wr(1'b0, {m, 27'h0});
    endtask

    task automatic send_frame(input logic [47:0] d, input bit gaps);
        for (int i = 0; i < 6; i++) begin
            rx_valid = 1'b1; rx_sof = (i == 0); rx_byte = d[i*8 +: 8];
            @(negedge clk);
            if (gaps) begin
                rx_valid = 1'b0;
                @(negedge clk);
            end
            if (i == 4) chk("R9 no verdict before sixth byte", 32'(dec_valid), 0);
        end
        rx_valid = 1'b0; rx_sof = 1'b0;
    endtask

    function automatic logic [1:0] exp_class(input logic [47:0] d);
        if (&d) return 2'd2;
        if (d[0]) return 2'd1;
        return 2'd0;
    endfunction

    function automatic bit exp_accept(input logic [4:0] m, input logic [47:0] d, input logic [47:0] s);
        logic [1:0] c;
        c = exp_class(d);
        if (!m[4]) return 1'b0;
        return (c == 2'd2 && m[3]) || (c == 2'd1 && m[2]) || (c == 2'd0 && m[1]) || (d == s && m[0]);
    endfunction

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [47:0] dests [4];
        dests[0] = 48'hFFFFFFFFFFFF;
        dests[1] = 48'h0A00005E0001;
        dests[2] = STATION;
        dests[3] = 48'h554433221104;

        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        chk("R1 dec_valid", 32'(dec_valid), 0);
        chk("R1 dec_accept", 32'(dec_accept), 0);
        chk("R1 dec_class", 32'(dec_class), 0);
        chk("R1 rdata", cfg_rdata, 0);

        // R9 beats before any start-of-frame
        for (int i = 0; i < 7; i++) begin
            rx_valid = 1'b1; rx_sof = 1'b0; rx_byte = 8'hFF;
            @(negedge clk);
        end
        rx_valid = 1'b0;
        @(negedge clk);
        chk("R9 pre-sof beats ignored", 32'(dec_valid), 0);

        // R2 station words and readback
        load_station(STATION);
        for (int k = 0; k < 3; k++) begin
            reg_wr(1'b0, 32'(k * 2));
            chk("R2 word readback", cfg_rdata, {16'h0, STATION[k*16 +: 16]});
        end
        reg_wr(1'b0, 32'd6);
        reg_wr(1'b1, 32'h0000BEEF);
        chk("R2 unused selection reads zero", cfg_rdata, 0);
        for (int k = 0; k < 3; k++) begin
            reg_wr(1'b0, 32'(k * 2));
            chk("R2 words untouched by unused selection", cfg_rdata, {16'h0, STATION[k*16 +: 16]});
        end

        // R3 mode write keeps the selection
        reg_wr(1'b0, 32'd4);
        set_mode(5'b10001);
        chk("R3 selection kept across mode load", cfg_rdata, {16'h0, STATION[47:32]});
        send_frame(STATION, 1'b0);
        chk("R2 byte order gives exact match", 32'(dec_accept), 1);

        // R3 selection write drops enable but keeps flags
        set_mode(5'b11111);
        reg_wr(1'b0, 32'd0);
        send_frame(dests[0], 1'b0);
        chk("R3 selection write disables", 32'(dec_accept), 0);
        reg_wr(1'b0, {5'b10000, 27'h0});
        send_frame(dests[0], 1'b0);
        chk("R3 flags reloaded off", 32'(dec_accept), 0);

        // R4..R8 sweep over every mode and destination kind
        for (int m = 0; m < 32; m++) begin
            for (int k = 0; k < 4; k++) begin
                set_mode(5'(m));
                send_frame(dests[k], 1'b0);
                chk("R9 verdict valid", 32'(dec_valid), 1);
                chk("R5 R6 R7 class", 32'(dec_class), 32'(exp_class(dests[k])));
                if (m < 16)
                    chk("R4 disabled rejects", 32'(dec_accept), 0);
                else
                    chk("R5 R6 R7 R8 accept", 32'(dec_accept), 32'(exp_accept(5'(m), dests[k], STATION)));
            end
        end

        // R8 exact match on a multicast station with the multicast flag off
        load_station(MC_STATION);
        set_mode(5'b10001);
        send_frame(MC_STATION, 1'b0);
        chk("R8 multicast exact class", 32'(dec_class), 1);
        chk("R8 multicast exact accept", 32'(dec_accept), 1);
        send_frame(dests[1], 1'b0);
        chk("R8 other multicast rejected", 32'(dec_accept), 0);

        // R9 gaps, trailing beats, hold, start-of-frame clear
        set_mode(5'b10100);
        send_frame(dests[1], 1'b1);
        chk("R9 gapped frame valid", 32'(dec_valid), 1);
        chk("R6 gapped frame accept", 32'(dec_accept), 1);
        for (int i = 0; i < 5; i++) begin
            rx_valid = 1'b1; rx_sof = 1'b0; rx_byte = 8'h00;
            @(negedge clk);
        end
        rx_valid = 1'b0;
        repeat (3) @(negedge clk);
        chk("R9 trailing beats keep verdict", {30'h0, dec_valid, dec_accept}, 32'h3);
        chk("R9 trailing beats keep class", 32'(dec_class), 1);
        rx_valid = 1'b1; rx_sof = 1'b1; rx_byte = 8'h02;
        @(negedge clk);
        rx_valid = 1'b0; rx_sof = 1'b0;
        chk("R9 sof clears verdict", 32'(dec_valid), 0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule